// File: doc/BRIEF.md
# Channel Limit Checker with Majority-Voted Regulator Inhibits

This block watches a set of monitoring channels held in an external sample memory and compares each one against its own upper and lower bound, which come from a separate limit memory. It steps through the channels in a fixed cycle and drives one address that both memories share. Each memory returns its data one clock after the address is presented. A channel whose sample lies outside its bounds sets a fault bit. The fault bit stays set until the host clears it.

The channels are grouped evenly over the regulators. Every regulator has an inhibit line that switches it off. A regulator is inhibited when the host has not enabled it, or when any channel of its group holds a fault. Samples and limits are plain unsigned ADC codes. For the current channels the analog front end is scaled at one ampere per volt, with a two-volt full scale, so the limits are written in the same codes.

The fault bits, the host enable bits and the inhibit outputs are each kept in three copies. What leaves the block is always the bitwise majority of the three copies. On every clock all three copies are loaded with the next value, and that value is computed from the voted state. A single flipped bit therefore never reaches an output, and it is overwritten at the next edge.

Top module: `limit_guard`

## Requirements
- R1: While reset is held and after it is released, with no host write, every fault bit reads 0, every enable bit reads 0 and every inhibit output reads 1.
- R2: `scan_addr` steps through channels 0, 1, …, NCH-1 and then wraps to 0. It advances by one channel on every clock after reset.
- R3: A channel is out of range when its sample is strictly greater than its upper limit or strictly less than its lower limit, with all three compared as unsigned values. A sample equal to either limit is in range. When `scan_addr` shows channel c in cycle k, the fault bit for c reads 1 in cycle k+2 if the data returned for c was out of range.
- R4: A fault bit stays at 1 after its sample returns to range. It is cleared only by a cycle with `clr_we`=1 and the bit at position c of `clr_mask` set to 1. Bits whose mask bit is 0 keep their value.
- R5: When a clear and a detected fault for the same channel fall in the same cycle, the fault bit ends at 1.
- R6: Regulator r covers channels r·(NCH/NREG) to r·(NCH/NREG)+NCH/NREG-1. `inh[r]` equals the inverse of `en_q[r]` ORed with the OR of those fault bits, taken from the previous cycle.
- R7: A cycle with `en_we`=1 loads `en_data` into the enable bits. The new value appears on `en_q` in the next cycle. With `en_we`=0 the enable bits hold their value.
- R8: Fault, enable and inhibit state each sit in three copies. All three copies are rewritten every cycle from the majority value, so with no disturbance the copies always agree and the readback holds steady.
- R9: An inhibit output rises exactly one cycle after a fault bit of its group rises, provided it was low before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_addr | output | $clog2(NCH) | Channel index presented to the sample and limit memories |
| smp_data | input | DW | Sample for the channel addressed one cycle earlier |
| lim_hi | input | DW | Upper limit for the channel addressed one cycle earlier |
| lim_lo | input | DW | Lower limit for the channel addressed one cycle earlier |
| clr_we | input | 1 | Fault clear strobe |
| clr_mask | input | NCH | Channels whose fault bit is cleared by the strobe |
| en_we | input | 1 | Enable write strobe |
| en_data | input | NREG | New regulator enable bits, 1 lets a regulator run |
| fault_q | output | NCH | Voted per-channel fault bits |
| en_q | output | NREG | Voted regulator enable bits |
| inh | output | NREG | Voted regulator inhibit lines, 1 switches the regulator off |

## Verification
The bench builds the block with four channels, two regulators and four-bit samples, so each regulator covers two channels. With four-bit codes the bench can step every sample value against a spread of lower and upper limits, including every case where the sample equals a limit, and compare the fault bit and the inhibit line with the range rule. Two regulators are few enough that every combination of enable bits can be driven. A scan of only four channels makes it cheap to line a clear strobe up with the exact cycle in which one channel is compared, which is how the set-over-clear priority and the one-cycle inhibit latency are checked.

// File: rtl/limit_guard_pkg.sv
package limit_guard_pkg;

  // Range rule: out of range when strictly above upper or strictly below lower.
  function automatic logic beyond_limits(input logic [31:0] smp,
                                         input logic [31:0] upper,
                                         input logic [31:0] lower);
    return (smp > upper) || (smp < lower);
  endfunction

  // Bitwise two-of-three majority over a 32-bit slice.
  function automatic logic [31:0] vote3(input logic [31:0] a,
                                        input logic [31:0] b,
                                        input logic [31:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/lg_tmr_reg.sv
module lg_tmr_reg #(
  parameter int          W       = 8,
  parameter logic [31:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         agree
);
  import limit_guard_pkg::*;

  localparam logic [W-1:0] RV = RST_VAL[W-1:0];

  logic [W-1:0] cp0, cp1, cp2;
  logic [31:0]  voted;

  // All three copies are reloaded each edge; d is derived from the voted q.
  always_ff @(posedge clk) begin
    if (rst) begin
      cp0 <= RV;
      cp1 <= RV;
      cp2 <= RV;
    end else begin
      cp0 <= d;
      cp1 <= d;
      cp2 <= d;
    end
  end

  assign voted = vote3(32'(cp0), 32'(cp1), 32'(cp2));
  assign q     = voted[W-1:0];
  assign agree = (cp0 == cp1) && (cp1 == cp2);

endmodule

// File: rtl/lg_scan.sv
module lg_scan #(
  parameter int NCH = 16,
  parameter int DW  = 12,
  parameter int AW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [AW-1:0]  scan_addr,
  input  logic [DW-1:0]  smp_data,
  input  logic [DW-1:0]  lim_hi,
  input  logic [DW-1:0]  lim_lo,
  output logic [NCH-1:0] set_hit
);
  import limit_guard_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(NCH - 1);

  logic [AW-1:0] ch_cnt;
  logic [AW-1:0] ch_d;
  logic          vld_d;
  logic          beyond;

  // Address counter and one-stage pipeline matching the memory read latency.
  always_ff @(posedge clk) begin
    if (rst) begin
      ch_cnt <= '0;
      ch_d   <= '0;
      vld_d  <= 1'b0;
    end else begin
      ch_cnt <= (ch_cnt == LAST) ? '0 : ch_cnt + 1'b1;
      ch_d   <= ch_cnt;
      vld_d  <= 1'b1;
    end
  end

  assign scan_addr = ch_cnt;
  assign beyond    = beyond_limits(32'(smp_data), 32'(lim_hi), 32'(lim_lo));

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_hit
      assign set_hit[c] = vld_d && beyond && (ch_d == AW'(c));
    end
  endgenerate

endmodule

// File: rtl/lg_group.sv
module lg_group #(
  parameter int NCH  = 16,
  parameter int NREG = 8
) (
  input  logic [NCH-1:0]  fault,
  output logic [NREG-1:0] any
);
  localparam int CPR = NCH / NREG;

  generate
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      assign any[r] = |fault[r*CPR +: CPR];
    end
  endgenerate

endmodule

// File: rtl/limit_guard.sv
module limit_guard #(
  parameter int NCH  = 16,
  parameter int NREG = 8,
  parameter int DW   = 12,
  parameter int AW   = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [AW-1:0]   scan_addr,
  input  logic [DW-1:0]   smp_data,
  input  logic [DW-1:0]   lim_hi,
  input  logic [DW-1:0]   lim_lo,
  input  logic            clr_we,
  input  logic [NCH-1:0]  clr_mask,
  input  logic            en_we,
  input  logic [NREG-1:0] en_data,
  output logic [NCH-1:0]  fault_q,
  output logic [NREG-1:0] en_q,
  output logic [NREG-1:0] inh
);

  // Named internal events, also used by the bound checker.
  logic [NCH-1:0]  set_hit;
  logic [NCH-1:0]  clr_eff;
  logic [NCH-1:0]  fault_n;
  logic [NREG-1:0] en_n;
  logic [NREG-1:0] inh_n;
  logic [NREG-1:0] grp_any;
  logic            agree_f, agree_e, agree_i;
  logic            copies_agree;

  lg_scan #(.NCH(NCH), .DW(DW), .AW(AW)) u_scan (
    .clk      (clk),
    .rst      (rst),
    .scan_addr(scan_addr),
    .smp_data (smp_data),
    .lim_hi   (lim_hi),
    .lim_lo   (lim_lo),
    .set_hit  (set_hit)
  );

  lg_group #(.NCH(NCH), .NREG(NREG)) u_group (
    .fault(fault_q),
    .any  (grp_any)
  );

  // Next-state rules, all evaluated on the voted state.
  assign clr_eff = clr_we ? clr_mask : '0;
  assign fault_n = (fault_q & ~clr_eff) | set_hit;
  assign en_n    = en_we ? en_data : en_q;
  assign inh_n   = ~en_q | grp_any;

  lg_tmr_reg #(.W(NCH), .RST_VAL(32'h0)) u_fault_tmr (
    .clk(clk), .rst(rst), .d(fault_n), .q(fault_q), .agree(agree_f)
  );

  lg_tmr_reg #(.W(NREG), .RST_VAL(32'h0)) u_en_tmr (
    .clk(clk), .rst(rst), .d(en_n), .q(en_q), .agree(agree_e)
  );

  lg_tmr_reg #(.W(NREG), .RST_VAL(32'hFFFF_FFFF)) u_inh_tmr (
    .clk(clk), .rst(rst), .d(inh_n), .q(inh), .agree(agree_i)
  );

  assign copies_agree = agree_f && agree_e && agree_i;

endmodule

// File: rtl/limit_guard_chk.sv
module limit_guard_chk #(
  parameter int NCH  = 16,
  parameter int NREG = 8,
  parameter int AW   = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   scan_addr,
  input logic            clr_we,
  input logic [NCH-1:0]  clr_mask,
  input logic [NCH-1:0]  fault_q,
  input logic [NREG-1:0] en_q,
  input logic [NREG-1:0] inh,
  input logic [NREG-1:0] grp_any,
  input logic [NCH-1:0]  set_hit,
  input logic            copies_agree
);
  localparam logic [AW-1:0] LAST = AW'(NCH - 1);

  logic [NCH-1:0] keep;
  assign keep = fault_q & ~(clr_we ? clr_mask : '0);

  a_r1_reset_state: assert property (@(posedge clk)
    $fell(rst) |-> (fault_q == '0 && en_q == '0 && inh == '1));

  a_r2_scan_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (scan_addr == (($past(scan_addr) == LAST) ? '0 : $past(scan_addr) + 1'b1)));

  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (keep != '0) |=> ((fault_q & $past(keep)) == $past(keep)));

  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_hit != '0) |=> ((fault_q & $past(set_hit)) == $past(set_hit)));

  a_r6_disabled_off: assert property (@(posedge clk) disable iff (rst)
    (en_q != '1) |=> ((inh & ~$past(en_q)) == ~$past(en_q)));

  a_r8_copies_agree: assert property (@(posedge clk) disable iff (rst)
    copies_agree);

  a_r9_fault_to_inh: assert property (@(posedge clk) disable iff (rst)
    (grp_any != '0) |=> ((inh & $past(grp_any)) == $past(grp_any)));

endmodule

bind limit_guard limit_guard_chk #(.NCH(NCH), .NREG(NREG), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .scan_addr   (scan_addr),
  .clr_we      (clr_we),
  .clr_mask    (clr_mask),
  .fault_q     (fault_q),
  .en_q        (en_q),
  .inh         (inh),
  .grp_any     (grp_any),
  .set_hit     (set_hit),
  .copies_agree(copies_agree)
);

// File: tb/sim_limit_guard.sv
`timescale 1ns/1ps
module sim_limit_guard;
  localparam int NCH  = 4;
  localparam int NREG = 2;
  localparam int DW   = 4;
  localparam int AW   = 2;
  localparam int SETTLE = 2*NCH + 2;

  logic            clk = 1'b0;
  logic            rst;
  logic [AW-1:0]   scan_addr;
  logic [DW-1:0]   smp_data, lim_hi, lim_lo;
  logic            clr_we;
  logic [NCH-1:0]  clr_mask;
  logic            en_we;
  logic [NREG-1:0] en_data;
  logic [NCH-1:0]  fault_q;
  logic [NREG-1:0] en_q;
  logic [NREG-1:0] inh;

  logic [DW-1:0] m_smp [NCH];
  logic [DW-1:0] m_hi  [NCH];
  logic [DW-1:0] m_lo  [NCH];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  limit_guard #(.NCH(NCH), .NREG(NREG), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .scan_addr(scan_addr),
    .smp_data(smp_data), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .clr_we(clr_we), .clr_mask(clr_mask), .en_we(en_we), .en_data(en_data),
    .fault_q(fault_q), .en_q(en_q), .inh(inh)
  );

  // Memory models with one clock of read latency.
  always @(posedge clk) begin
    smp_data <= m_smp[scan_addr];
    lim_hi   <= m_hi[scan_addr];
    lim_lo   <= m_lo[scan_addr];
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear(input logic [NCH-1:0] m);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic do_enable(input logic [NREG-1:0] v);
    en_we = 1'b1; en_data = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic wait_addr(input int a);
    while (int'(scan_addr) != a) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clr_we = 1'b0; clr_mask = '0; en_we = 1'b0; en_data = '0;
    for (int i = 0; i < NCH; i++) begin
      m_smp[i] = 4'd7; m_hi[i] = 4'd15; m_lo[i] = 4'd0;
    end
    tick(3);
    // R1: state during reset
    chk("R1 fault in reset", int'(fault_q), 0);
    chk("R1 enable in reset", int'(en_q), 0);
    chk("R1 inhibit in reset", int'(inh), 3);
    rst = 1'b0;
    tick(SETTLE);
    chk("R1 fault after reset", int'(fault_q), 0);
    chk("R1 inhibit after reset", int'(inh), 3);

    // R2: scan order
    begin
      int prev;
      prev = int'(scan_addr);
      for (int i = 0; i < 9; i++) begin
        tick(1);
        chk("R2 scan step", int'(scan_addr), (prev + 1) % NCH);
        prev = int'(scan_addr);
      end
    end

    // R7 and R6: every enable combination, no faults present
    for (int v = 0; v < 4; v++) begin
      do_enable(NREG'(v));
      tick(2);
      chk("R7 enable readback", int'(en_q), v);
      chk("R6 inhibit from enable", int'(inh), (~v) & 3);
    end
    tick(3);
    chk("R7 enable held", int'(en_q), 3);

    // R3 sweep on channel 0, R6 inhibit of regulator 0
    for (int lo = 0; lo < 16; lo += 4) begin
      for (int hi = lo; hi < 16; hi += 3) begin
        for (int s = 0; s < 16; s++) begin
          bit exp_f;
          m_lo[0] = DW'(lo); m_hi[0] = DW'(hi); m_smp[0] = DW'(s);
          tick(SETTLE);
          do_clear('1);
          tick(SETTLE);
          exp_f = !(s >= lo && s <= hi);
          chk($sformatf("R3 range s=%0d lo=%0d hi=%0d", s, lo, hi), int'(fault_q[0]), int'(exp_f));
          chk("R6 inhibit follows group fault", int'(inh[0]), int'(exp_f));
          chk("R3 other channels clean", int'(fault_q[NCH-1:1]), 0);
        end
      end
    end
    m_lo[0] = 4'd0; m_hi[0] = 4'd15; m_smp[0] = 4'd7;
    tick(SETTLE); do_clear('1); tick(SETTLE);

    // R4: sticky bits and selective clear
    m_hi[1] = 4'd9; m_smp[1] = 4'd15;
    m_lo[3] = 4'd2; m_smp[3] = 4'd0;
    tick(SETTLE);
    m_hi[1] = 4'd15; m_lo[3] = 4'd0; m_smp[1] = 4'd7; m_smp[3] = 4'd7;
    tick(SETTLE);
    chk("R4 sticky after return to range", int'(fault_q), 4'b1010);
    do_clear(4'b0010);
    tick(2);
    chk("R4 masked clear", int'(fault_q), 4'b1000);
    chk("R6 inhibit per group", int'(inh), 2'b10);
    do_clear(4'b1000);
    tick(2);
    chk("R4 clear remaining", int'(fault_q), 0);
    chk("R6 inhibits released", int'(inh), 0);

    // R8: voted readback steady through continuous rewriting
    begin
      logic [NCH-1:0] f0;
      logic [NREG-1:0] e0;
      f0 = fault_q; e0 = en_q;
      tick(40);
      chk("R8 fault steady", int'(fault_q), int'(f0));
      chk("R8 enable steady", int'(en_q), int'(e0));
    end

    // R5: clear coinciding with detection of channel 0
    m_hi[0] = 4'd9; m_smp[0] = 4'd15;
    tick(SETTLE);
    chk("R5 setup fault", int'(fault_q[0]), 1);
    wait_addr(0);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = 4'b0001;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = '0;
    chk("R5 set wins over clear", int'(fault_q[0]), 1);
    do_clear(4'b0001);
    chk("R4 clear off compare cycle", int'(fault_q[0]), 0);
    m_hi[0] = 4'd15; m_smp[0] = 4'd7;
    tick(SETTLE); do_clear('1); tick(SETTLE);
    chk("R6 all clear before latency test", int'(inh), 0);

    // R3 timing and R9 latency on channel 2 / regulator 1
    wait_addr(2);
    m_hi[2] = 4'd9; m_smp[2] = 4'd15;
    @(negedge clk);
    chk("R3 fault not yet at k+1", int'(fault_q[2]), 0);
    @(negedge clk);
    chk("R3 fault at k+2", int'(fault_q[2]), 1);
    chk("R9 inhibit still low", int'(inh[1]), 0);
    @(negedge clk);
    chk("R9 inhibit one cycle later", int'(inh[1]), 1);
    chk("R6 other regulator unaffected", int'(inh[0]), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule